// File: doc/BRIEF.md
# Reloading Countdown Timer

This block is a programmable down-counter with a 12-bit reload value. Software writes the value as two bytes. A write to the low byte only stores it. A write to the high byte completes the value and restarts the countdown from it. Each tick of the selected rate moves the counter one step toward zero. The tick that finds the counter at zero produces a one-cycle expiry pulse and reloads the counter from the stored value.

A select input picks the tick rate: a fast tick or a slow line-rate tick. A stored value of zero stops the timer after one final expiry. A blink output changes state on every fourth expiry, for use in text display logic. Reads have no effect on the block, so it has no read data port.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset `expire` and `blink` are 0. No expiry pulse appears until the first high-byte write.
- R2: A write with `wr_hi`=0 stores `wr_data` as bits 7:0 of the reload value. It does not restart or alter the running count.
- R3: A write with `wr_hi`=1 stores `wr_data[3:0]` as bits 11:8 of the reload value and ignores `wr_data[7:4]`. It loads the counter with the full 12-bit value and starts counting. In the same cycle it overrides any tick, so no expiry comes from that cycle.
- R4: A reload value N (1..4095) gives one expiry every N+1 selected ticks, repeating with automatic reload. A value of 1 therefore expires every 2 ticks.
- R5: `expire` is high for exactly one cycle, in the cycle after the clock edge that sampled the expiring tick.
- R6: With `fast_sel`=1 only `fast_tick` advances the counter. With `fast_sel`=0 only `slow_tick` does. The other tick input has no effect.
- R7: When the counter expires and the reload value is 0, exactly one pulse is produced. The timer then stays halted with no further pulses until the next high-byte write.
- R8: `blink` toggles on the 4th, 8th, 12th, ... expiry counted since reset. It changes at the same edge that raises `expire` and never at any other time.
- R9: In a cycle with no selected tick, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| wr_data | input | 8 | Write data |
| fast_sel | input | 1 | 1 selects the fast tick, 0 the slow tick |
| fast_tick | input | 1 | Fast tick enable, one cycle wide |
| slow_tick | input | 1 | Slow line-rate tick enable, one cycle wide |
| expire | output | 1 | One-cycle expiry pulse |
| blink | output | 1 | Blink state |

## Verification
The bench predicts the cycle of every expiry from the value it writes and the tick spacing. A design that counts N ticks instead of N+1 therefore misses each expected cycle. The bench stores a new low byte in the middle of a countdown and expects the current period to finish unchanged. A design that restarts on that write would pulse early.

A zero value must give a single pulse and then stay silent for a long idle window. A design that keeps expiring, or never pulses, is reported. The bench also sets the upper nibble of the high byte, runs the fast tick continuously while the slow tick is selected, and tracks the blink state across every expiry since reset.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic {
      SRC_SLOW = 1'b0,
      SRC_FAST = 1'b1
   } tick_src_e;

   localparam int unsigned DEF_CNT_W     = 12;
   localparam int unsigned DEF_BYTE_W    = 8;
   localparam int unsigned DEF_BLINK_LOG = 2;

endpackage

// File: rtl/tick_source_mux.sv
module tick_source_mux
   import tick_timer_pkg::*;
#(
   parameter bit TICK_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_sel,
   input  logic fast_tick,
   input  logic slow_tick,
   output logic tick
);

   tick_src_e src;
   logic      raw_tick;

   assign src      = tick_src_e'(fast_sel);
   assign raw_tick = (src == SRC_FAST) ? fast_tick : slow_tick;

   generate
      if (TICK_REG) begin : g_reg
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= raw_tick;
         end
         assign tick = tick_q;
      end else begin : g_comb
         assign tick = raw_tick;
      end
   endgenerate

endmodule

// File: rtl/reload_count_core.sv
module reload_count_core #(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              tick,
   output logic              fire,
   output logic              expire_q
);

   localparam int unsigned HI_W = CNT_W - BYTE_W;

   logic [BYTE_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  reload;
   logic              armed_q;
   logic              hi_wr;
   logic              lo_wr;
   logic              unused_data_top;

   assign unused_data_top = ^wr_data[BYTE_W-1:HI_W];
   assign hi_wr  = wr_en && wr_hi;
   assign lo_wr  = wr_en && !wr_hi;
   assign reload = {hi_q, lo_q};
   assign fire   = tick && armed_q && !hi_wr && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q     <= '0;
         hi_q     <= '0;
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= fire;
         if (lo_wr) lo_q <= wr_data;
         if (hi_wr) begin
            hi_q    <= wr_data[HI_W-1:0];
            cnt_q   <= {wr_data[HI_W-1:0], lo_q};
            armed_q <= 1'b1;
         end else if (tick && armed_q) begin
            if (cnt_q == '0) begin
               cnt_q <= reload;
               if (reload == '0) armed_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   assert_lo_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !tick) |=> ($stable(cnt_q) && $stable(armed_q)));

   assert_hi_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> (armed_q && !expire_q));

   assert_halt_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !hi_wr) |=> (!armed_q && !expire_q));

   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hi_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic blink
);

   logic blink_q;

   generate
      if (DIV_LOG2 == 0) begin : g_every
         always_ff @(posedge clk) begin
            if (!rst_n)   blink_q <= 1'b0;
            else if (evt) blink_q <= ~blink_q;
         end
      end else begin : g_div
         logic [DIV_LOG2-1:0] phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= '0;
               blink_q <= 1'b0;
            end else if (evt) begin
               phase_q <= phase_q + DIV_LOG2'(1);
               if (&phase_q) blink_q <= ~blink_q;
            end
         end
      end
   endgenerate

   assign blink = blink_q;

endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter int unsigned BYTE_W    = DEF_BYTE_W,
   parameter int unsigned BLINK_LOG = DEF_BLINK_LOG,
   parameter bit          TICK_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              fast_sel,
   input  logic              fast_tick,
   input  logic              slow_tick,
   output logic              expire,
   output logic              blink
);

   initial begin
      assert (CNT_W > BYTE_W && CNT_W < 2 * BYTE_W)
         else $error("CNT_W must exceed BYTE_W and be below twice BYTE_W");
      assert (BLINK_LOG <= 8)
         else $error("BLINK_LOG out of range");
   end

   logic tick;
   logic fire;

   tick_source_mux #(.TICK_REG(TICK_REG)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_sel  (fast_sel),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .tick      (tick)
   );

   reload_count_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_hi    (wr_hi),
      .wr_data  (wr_data),
      .tick     (tick),
      .fire     (fire),
      .expire_q (expire)
   );

   blink_divider #(.DIV_LOG2(BLINK_LOG)) u_blink (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (fire),
      .blink (blink)
   );

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   assert_blink_only_on_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(blink) |-> expire);

   generate
      if (!TICK_REG) begin : g_tick_chk
         assert_expiry_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
            expire |-> $past(fast_sel ? fast_tick : slow_tick));
      end
   endgenerate

endmodule

// File: tb/tick_reload_timer_bench.sv
`timescale 1ns/1ps
module tick_reload_timer_bench;

   localparam int SL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = '0;
   logic       fast_sel = 1'b1;
   logic       fast_tick = 1'b1;
   logic       slow_tick = 1'b0;
   logic       expire;
   logic       blink;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   int total_exp = 0;
   int sph = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tick_reload_timer u_tick_reload_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
      .fast_sel(fast_sel), .fast_tick(fast_tick), .slow_tick(slow_tick),
      .expire(expire), .blink(blink)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic step(input bit en, input bit hi, input logic [7:0] d);
      @(negedge clk);
      wr_en = en; wr_hi = hi; wr_data = d;
      if (en && hi) begin
         slow_tick = 1'b0; sph = 0;
      end else begin
         slow_tick = (sph == SL - 1);
         sph = (sph == SL - 1) ? 0 : sph + 1;
      end
   endtask

   // monitor: pops expected expiry cycles and checks blink (R4, R5, R8)
   always @(negedge clk) begin
      if (rst_n && expire) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R7 unexpected expiry", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(cyc == e, "R4 expiry cycle", cyc, e);
         end
         total_exp++;
         chk(blink == ((total_exp / 4) % 2), "R8 blink state", blink, (total_exp / 4) % 2);
      end
   end

   // lo write, then hi write; returns the edge index of the hi write
   task automatic start_cfg(input logic [7:0] lo, input logic [7:0] hi, input bit sel, output int c0);
      fast_sel = sel;
      step(1'b1, 1'b0, lo);
      step(1'b1, 1'b1, hi);
      c0 = cyc + 1;
      chk(exp_q.size() == 0, "R4 pending expiries drained", exp_q.size(), 0);
   endtask

   task automatic hold_until(input int last);
      while (cyc < last - 1) step(1'b0, 1'b0, 8'h00);
   endtask

   task automatic run_case(input logic [7:0] lo, input logic [7:0] hi, input bit sel,
                           input int n, input int extra, input string req);
      int c0, per, last;
      start_cfg(lo, hi, sel, c0);
      per = ({hi[3:0], lo} + 1) * (sel ? 1 : SL);
      for (int k = 1; k <= n; k++) exp_q.push_back(c0 + k * per);
      last = c0 + n * per + extra;
      hold_until(last);
      $display("case %s done at cycle %0d", req, cyc);
   endtask

   initial begin : watchdog
      #(5ns * 20000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : driver
      int c0, c1, bl;
      // R1 reset state
      repeat (3) step(1'b0, 1'b0, 8'h00);
      chk(expire == 1'b0, "R1 expire in reset", expire, 0);
      chk(blink == 1'b0, "R1 blink in reset", blink, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (20) step(1'b0, 1'b0, 8'h00);
      chk(expire == 1'b0 && blink == 1'b0, "R1 idle after reset", expire + blink, 0);

      // R4, R8: N=5, eight expiries, blink toggles twice
      run_case(8'd5, 8'h00, 1'b1, 8, 0, "R4 N=5");
      // R4: N=1 behaves as 2
      run_case(8'd1, 8'h00, 1'b1, 6, 0, "R4 N=1");
      // R3: high nibble from wr_data[3:0], top bits ignored -> 0x105
      run_case(8'h05, 8'hF1, 1'b1, 2, 0, "R3 value 0x105");
      // R6, R9: slow tick selected while fast tick runs every cycle
      run_case(8'd3, 8'h00, 1'b0, 5, 0, "R6 slow source");
      // R7: zero value gives one pulse and halts
      run_case(8'd0, 8'h00, 1'b1, 1, 40, "R7 zero halt");
      chk(blink == ((total_exp / 4) % 2), "R8 blink frozen while halted", blink, (total_exp / 4) % 2);

      // R2: low write mid-count does not restart; new period used after expiry
      start_cfg(8'd10, 8'h00, 1'b1, c0);
      exp_q.push_back(c0 + 11);
      exp_q.push_back(c0 + 14);
      exp_q.push_back(c0 + 17);
      repeat (3) step(1'b0, 1'b0, 8'h00);
      step(1'b1, 1'b0, 8'd2);
      hold_until(c0 + 17);

      // R3: second high write restarts the count
      start_cfg(8'd7, 8'h00, 1'b1, c0);
      repeat (4) step(1'b0, 1'b0, 8'h00);
      step(1'b1, 1'b1, 8'h00);
      c1 = cyc + 1;
      chk(c1 == c0 + 5, "R3 restart edge", c1, c0 + 5);
      exp_q.push_back(c1 + 8);
      exp_q.push_back(c1 + 16);
      hold_until(c1 + 16);

      // final halt, then confirm silence
      run_case(8'd0, 8'h00, 1'b1, 1, 20, "R7 final halt");
      bl = blink;
      repeat (10) step(1'b0, 1'b0, 8'h00);
      chk(exp_q.size() == 0, "R7 all expiries seen", exp_q.size(), 0);
      chk(blink == bl, "R8 blink stable after halt", blink, bl);
      chk(total_exp == 28, "R4 total expiry count", total_exp, 28);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule